// File: doc/BRIEF.md
# Reference Lock Monitor with Loop-Bandwidth Control

This block watches a slow, possibly noisy reference clock from inside a fast local clock domain. It measures each reference period as a count of local clock cycles, qualifies a run of steady periods before declaring lock, and then keeps checking the reference. It drops lock when any of these happens:
- the period jumps between neighbouring measurements;
- an edge goes missing;
- the period wanders too far from the value held when lock was won;
- the mode pins change, which asks for a relock.

The block also produces a 3-bit loop-bandwidth code for a downstream digital loop filter. Code k stands for a corner of 2^k Hz. The code stays at its widest value whenever the loop is not locked. Once lock is held, it walks down one step at a time to a programmed floor. An optional startup hold keeps the monitor idle until the mode pins have been changed a set number of times after reset.

Top module: `refmon_lock_monitor`

## Requirements
- R1: After reset, `state_o` is IDLE (encoding 00), `locked_o` is 0 and `bw_code_o` is 3'b111. The other state encodings are ACQUIRE 01, LOCKED 10 and UNLOCKED 11.
- R2: With `startup_hold` high, the block stays in IDLE until the synchronised mode pins have changed value at least STARTUP_TOGGLES (3) times. With `startup_hold` low, it leaves IDLE for ACQUIRE right after reset.
- R3: In ACQUIRE, the first measured period is captured and is not counted. Lock (state 10, `locked_o` high) is declared only after LOCK_PERIODS further periods with no step, and only once at least LOCK_CYCLES local cycles have passed since that first period. The later of the two conditions decides.
- R4: In ACQUIRE or LOCKED, a measured period whose difference from the previous period exceeds the previous period shifted right by 4 moves the block to UNLOCKED.
- R5: In LOCKED, a measured period whose difference from the period captured at lock exceeds floor(base*19/64) (about 30 %) moves the block to UNLOCKED. Slower changes that stay within that bound keep lock.
- R6: When more than twice the last period passes with no reference rising edge, the block moves to UNLOCKED.
- R7: Once the startup gate is open, any change of the mode pins forces UNLOCKED, whatever the current state.
- R8: UNLOCKED moves to ACQUIRE at the next reference rising edge, and lock qualification restarts from nothing.
- R9: `bw_code_o` is 3'b111 in every state other than LOCKED, including on the cycle lock is entered.
- R10: While LOCKED, `bw_code_o` drops by one after every BW_STEP measured periods until it equals `bw_min`. It never goes below `bw_min`. If `bw_min` is raised above the current code, the code rises to `bw_min`.
- R11: When the period that would complete lock qualification is itself a step, the step wins: the block goes to UNLOCKED and never reports lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast local clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_in | input | 1 | Reference clock, asynchronous to clk |
| mode_in | input | MODE_W | Mode pins; changes act as toggles and relock requests |
| startup_hold | input | 1 | Keep the block idle until the mode pins have toggled enough times |
| bw_min | input | 3 | Floor for the bandwidth code (2^code Hz) |
| state_o | output | 2 | Monitor state: 00 idle, 01 acquire, 10 locked, 11 unlocked |
| locked_o | output | 1 | High while locked |
| bw_code_o | output | 3 | Loop-bandwidth code |

## Verification
Two decisions can land on the same reference edge: the measurement that completes lock qualification, and the step detector firing on that same measurement. The bench provokes this by sending a steady reference and then making exactly the qualifying period longer by a fifth, after enough local time has passed that only the period count still gates lock. It judges the outcome by requiring that `locked_o` is still low one period earlier and that the state reads UNLOCKED after the stepped edge, never LOCKED.

// File: rtl/refmon_pkg.sv
package refmon_pkg;

    parameter int unsigned PER_W = 20;
    parameter int unsigned BW_W  = 3;

    typedef logic [PER_W-1:0] per_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_ACQ  = 2'b01,
        ST_LOCK = 2'b10,
        ST_UNLK = 2'b11
    } mon_state_e;

    typedef struct packed {
        logic rise;
        logic tick;
        per_t len;
    } ref_meas_s;

    function automatic per_t abs_gap(per_t a, per_t b);
        return (a > b) ? (a - b) : (b - a);
    endfunction

    // Neighbouring periods differ by more than 1/16 of the earlier one.
    function automatic logic is_step(per_t prev, per_t cur);
        return abs_gap(prev, cur) > (prev >> 4);
    endfunction

    // Deviation from the lock-time period exceeds base*19/64.
    function automatic logic is_drift(per_t base, per_t cur);
        logic [PER_W+4:0] wide;
        wide = {5'd0, base};
        wide = (wide << 4) + (wide << 1) + wide;
        return {5'd0, abs_gap(base, cur)} > (wide >> 6);
    endfunction

    function automatic logic over_time(per_t gone, per_t prev);
        return {1'b0, gone} > {prev, 1'b0};
    endfunction

endpackage

// File: rtl/refmon_period_meter.sv
module refmon_period_meter
    import refmon_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      ref_i,
    output ref_meas_s meas_o,
    output per_t      elapsed_o
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   last_q;
    logic                   seen_q;
    per_t                   cnt_q;
    logic                   rise;

    assign rise = sync_q[SYNC_STAGES-1] & ~last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            last_q <= 1'b0;
            seen_q <= 1'b0;
            cnt_q  <= '0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], ref_i};
            last_q <= sync_q[SYNC_STAGES-1];
            seen_q <= seen_q | rise;
            if (rise) begin
                cnt_q <= '0;
            end else if (cnt_q != '1) begin
                cnt_q <= cnt_q + per_t'(1);
            end
        end
    end

    always_comb begin
        meas_o.rise = rise;
        meas_o.tick = rise & seen_q;
        meas_o.len  = (cnt_q == '1) ? cnt_q : (cnt_q + per_t'(1));
    end

    assign elapsed_o = cnt_q;

    // R3: a measurement never follows another on the next cycle.
    assert_single_rise_R3: assert property (@(posedge clk) disable iff (rst)
        meas_o.rise |=> !meas_o.rise);

endmodule

// File: rtl/refmon_mode_watch.sv
module refmon_mode_watch #(
    parameter int unsigned MODE_W      = 3,
    parameter int unsigned TOGGLES     = 3,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [MODE_W-1:0] mode_i,
    input  logic              hold_i,
    output logic              gate_o,
    output logic              relock_o
);

    localparam int unsigned CW = $clog2(TOGGLES + 1);
    localparam int unsigned PW = $clog2(SYNC_STAGES + 1);

    logic [SYNC_STAGES-1:0][MODE_W-1:0] stg_q;
    logic [MODE_W-1:0]                  prev_q;
    logic [PW-1:0]                      prime_q;
    logic [CW-1:0]                      tog_q;
    logic                               gate_q;
    logic                               primed;
    logic                               change;

    assign primed = (prime_q == PW'(SYNC_STAGES));
    assign change = primed && (stg_q[SYNC_STAGES-1] != prev_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            stg_q   <= '0;
            prev_q  <= '0;
            prime_q <= '0;
            tog_q   <= '0;
            gate_q  <= 1'b0;
        end else begin
            stg_q  <= {stg_q[SYNC_STAGES-2:0], mode_i};
            prev_q <= stg_q[SYNC_STAGES-1];
            if (!primed) begin
                prime_q <= prime_q + PW'(1);
            end
            if (change && tog_q < CW'(TOGGLES)) begin
                tog_q <= tog_q + CW'(1);
            end
            gate_q <= !hold_i || (tog_q >= CW'(TOGGLES));
        end
    end

    assign gate_o   = gate_q;
    assign relock_o = change & gate_q;

    // R2: while held and short of toggles, the gate stays shut.
    assert_gate_shut_R2: assert property (@(posedge clk) disable iff (rst)
        (hold_i && $past(hold_i) && tog_q < CW'(TOGGLES)) |-> !gate_o);

endmodule

// File: rtl/refmon_bw_ctrl.sv
module refmon_bw_ctrl
    import refmon_pkg::*;
#(
    parameter int unsigned BW_STEP = 64
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            locked_i,
    input  logic            tick_i,
    input  logic [BW_W-1:0] min_i,
    output logic [BW_W-1:0] bw_o
);

    localparam int unsigned SW = (BW_STEP > 1) ? $clog2(BW_STEP) : 1;

    logic [SW-1:0]   cnt_q;
    logic [BW_W-1:0] bw_q;

    always_ff @(posedge clk) begin
        if (rst || !locked_i) begin
            bw_q  <= '1;
            cnt_q <= '0;
        end else if (bw_q < min_i) begin
            bw_q <= min_i;
        end else if (tick_i) begin
            if (cnt_q == SW'(BW_STEP - 1)) begin
                cnt_q <= '0;
                if (bw_q > min_i) begin
                    bw_q <= bw_q - BW_W'(1);
                end
            end else begin
                cnt_q <= cnt_q + SW'(1);
            end
        end
    end

    assign bw_o = bw_q;

    assert_wide_unlocked_R9: assert property (@(posedge clk) disable iff (rst)
        !locked_i |=> (bw_o == '1));

    assert_floor_R10: assert property (@(posedge clk) disable iff (rst)
        (locked_i && $past(locked_i) && $stable(min_i)) |-> (bw_o >= min_i));

    assert_single_step_R10: assert property (@(posedge clk) disable iff (rst)
        (locked_i && $past(locked_i) && $stable(min_i) && $past(bw_o) >= $past(min_i))
        |-> (bw_o == $past(bw_o) || bw_o == BW_W'($past(bw_o) - BW_W'(1))));

endmodule

// File: rtl/refmon_lock_monitor.sv
module refmon_lock_monitor
    import refmon_pkg::*;
#(
    parameter int unsigned MODE_W          = 3,
    parameter int unsigned LOCK_PERIODS    = 100,
    parameter int unsigned LOCK_CYCLES     = 250000,
    parameter int unsigned BW_STEP         = 64,
    parameter int unsigned STARTUP_TOGGLES = 3,
    parameter int unsigned SYNC_STAGES     = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ref_in,
    input  logic [MODE_W-1:0] mode_in,
    input  logic              startup_hold,
    input  logic [2:0]        bw_min,
    output logic [1:0]        state_o,
    output logic              locked_o,
    output logic [2:0]        bw_code_o
);

    localparam int unsigned SCW = $clog2(LOCK_PERIODS + 1);
    localparam int unsigned TCW = $clog2(LOCK_CYCLES + 1);

    ref_meas_s  meas;
    per_t       elapsed;
    logic       gate;
    logic       relock;

    mon_state_e st_q, st_d;
    per_t       prev_q, base_q;
    logic       have_q;
    logic [SCW-1:0] stab_q;
    logic [TCW-1:0] time_q;

    logic unlock, capture_first, accept, go_lock, stepped;

    refmon_period_meter #(.SYNC_STAGES(SYNC_STAGES)) u_meter (
        .clk       (clk),
        .rst       (rst),
        .ref_i     (ref_in),
        .meas_o    (meas),
        .elapsed_o (elapsed)
    );

    refmon_mode_watch #(
        .MODE_W      (MODE_W),
        .TOGGLES     (STARTUP_TOGGLES),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_mode (
        .clk      (clk),
        .rst      (rst),
        .mode_i   (mode_in),
        .hold_i   (startup_hold),
        .gate_o   (gate),
        .relock_o (relock)
    );

    refmon_bw_ctrl #(.BW_STEP(BW_STEP)) u_bw (
        .clk      (clk),
        .rst      (rst),
        .locked_i (st_q == ST_LOCK),
        .tick_i   (meas.tick),
        .min_i    (bw_min),
        .bw_o     (bw_code_o)
    );

    assign stepped = is_step(prev_q, meas.len) ||
                     ((st_q == ST_LOCK) && is_drift(base_q, meas.len));

    always_comb begin
        st_d          = st_q;
        unlock        = 1'b0;
        capture_first = 1'b0;
        accept        = 1'b0;
        go_lock       = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (relock)    st_d = ST_UNLK;
                else if (gate) st_d = ST_ACQ;
            end
            ST_ACQ, ST_LOCK: begin
                if (relock) begin
                    unlock = 1'b1;
                end else if (have_q && over_time(elapsed, prev_q)) begin
                    unlock = 1'b1;
                end else if (meas.tick) begin
                    if (!have_q)      capture_first = 1'b1;
                    else if (stepped) unlock = 1'b1;
                    else              accept = 1'b1;
                end
                if (unlock) begin
                    st_d = ST_UNLK;
                end else if (st_q == ST_ACQ && stab_q >= SCW'(LOCK_PERIODS) &&
                             time_q >= TCW'(LOCK_CYCLES)) begin
                    st_d    = ST_LOCK;
                    go_lock = 1'b1;
                end
            end
            ST_UNLK: begin
                if (!relock && meas.rise) st_d = ST_ACQ;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            prev_q <= '0;
            base_q <= '0;
            have_q <= 1'b0;
            stab_q <= '0;
            time_q <= '0;
        end else begin
            st_q <= st_d;
            if ((st_q != ST_ACQ && st_q != ST_LOCK) || st_d == ST_UNLK) begin
                have_q <= 1'b0;
                stab_q <= '0;
                time_q <= '0;
            end else begin
                if (capture_first) begin
                    prev_q <= meas.len;
                    have_q <= 1'b1;
                end
                if (accept) begin
                    prev_q <= meas.len;
                    if (st_q == ST_ACQ && stab_q < SCW'(LOCK_PERIODS)) begin
                        stab_q <= stab_q + SCW'(1);
                    end
                end
                if (have_q && st_q == ST_ACQ && time_q < TCW'(LOCK_CYCLES)) begin
                    time_q <= time_q + TCW'(1);
                end
                if (go_lock) begin
                    base_q <= accept ? meas.len : prev_q;
                end
            end
        end
    end

    assign state_o  = st_q;
    assign locked_o = (st_q == ST_LOCK);

    assert_idle_until_gate_R2: assert property (@(posedge clk) disable iff (rst)
        !gate |-> (st_q == ST_IDLE));

    assert_lock_qualified_R3: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_LOCK && $past(st_q) == ST_ACQ) |->
        ($past(stab_q) >= SCW'(LOCK_PERIODS) && $past(time_q) >= TCW'(LOCK_CYCLES)));

    assert_step_unlocks_R4: assert property (@(posedge clk) disable iff (rst)
        ((st_q == ST_ACQ || st_q == ST_LOCK) && have_q && meas.tick &&
         is_step(prev_q, meas.len)) |=> (st_q == ST_UNLK));

    assert_timeout_unlocks_R6: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_LOCK && over_time(elapsed, prev_q)) |=> (st_q == ST_UNLK));

    assert_relock_forces_R7: assert property (@(posedge clk) disable iff (rst)
        relock |=> (st_q == ST_UNLK));

endmodule

// File: tb/test_refmon_lock_monitor.sv
module test_refmon_lock_monitor;

    localparam int unsigned NPER = 8;
    localparam int unsigned NCYC = 200;
    localparam int unsigned STEP = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ref_in;
    logic [2:0] mode_in = '0;
    logic       startup_hold = 1'b1;
    logic [2:0] bw_min = 3'd2;
    logic [1:0] state_o;
    logic       locked_o;
    logic [2:0] bw_code_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;
    int ref_period = 40;
    bit ref_run = 0;
    int gp;
    event ref_rise;

    always #2 clk = ~clk;

    refmon_lock_monitor #(
        .MODE_W(3), .LOCK_PERIODS(NPER), .LOCK_CYCLES(NCYC), .BW_STEP(STEP),
        .STARTUP_TOGGLES(3), .SYNC_STAGES(2)
    ) i_refmon_lock_monitor (
        .clk(clk), .rst(rst), .ref_in(ref_in), .mode_in(mode_in),
        .startup_hold(startup_hold), .bw_min(bw_min), .state_o(state_o),
        .locked_o(locked_o), .bw_code_o(bw_code_o)
    );

    initial begin
        ref_in = 1'b0;
        forever begin
            @(negedge clk);
            if (ref_run) begin
                gp = ref_period;
                ref_in = 1'b1;
                -> ref_rise;
                repeat (gp / 2) @(negedge clk);
                ref_in = 1'b0;
                repeat (gp - gp / 2 - 1) @(negedge clk);
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset(input bit hold);
        ref_run = 0;
        wait_cyc(60);
        rst = 1'b1;
        mode_in = '0;
        startup_hold = hold;
        wait_cyc(5);
        rst = 1'b0;
        wait_cyc(2);
    endtask

    task automatic wait_lock(input int maxc);
        int took = 0;
        while (!locked_o && took < maxc) begin
            @(negedge clk);
            took++;
        end
    endtask

    task automatic t_reset_R1;
        do_reset(1'b1);
        chk("R1 state after reset", state_o, 0);
        chk("R1 locked after reset", locked_o, 0);
        chk("R1 bw after reset", bw_code_o, 7);
    endtask

    task automatic t_startup_R2;
        ref_period = 40;
        ref_run = 1;
        wait_cyc(300);
        chk("R2 idle with no toggles", state_o, 0);
        mode_in = 3'd1; wait_cyc(10);
        mode_in = 3'd3; wait_cyc(10);
        chk("R2 idle after two toggles", state_o, 0);
        mode_in = 3'd2; wait_cyc(10);
        chk("R2 acquire after third toggle", state_o, 1);
    endtask

    task automatic t_bw_R10;
        wait_lock(2000);
        chk("R3 lock reached", locked_o, 1);
        chk("R9 bw wide on lock entry", bw_code_o, 7);
        wait_cyc(100);
        chk("R10 bw before first step", bw_code_o, 7);
        wait_cyc(100);
        chk("R10 bw after first step", bw_code_o, 6);
        wait_cyc(1280);
        chk("R10 bw settles at floor", bw_code_o, 2);
        bw_min = 3'd5;
        wait_cyc(5);
        chk("R10 bw rises to raised floor", bw_code_o, 5);
    endtask

    task automatic t_relock_R7;
        @(ref_rise);
        wait_cyc(5);
        mode_in = mode_in ^ 3'b100;
        wait_cyc(8);
        chk("R7 relock forces unlocked", state_o, 3);
        chk("R7 locked low after relock", locked_o, 0);
        chk("R9 bw wide when unlocked", bw_code_o, 7);
    endtask

    task automatic t_step_R4;
        wait_lock(2000);
        chk("R4 locked before step", locked_o, 1);
        @(ref_rise);
        ref_period = 48;
        @(ref_rise);
        @(ref_rise);
        wait_cyc(10);
        chk("R4 step unlocks", state_o, 3);
        wait_cyc(48);
        chk("R8 next edge reacquires", state_o, 1);
    endtask

    task automatic t_drift_R5;
        ref_period = 40;
        wait_lock(3000);
        chk("R5 locked at base 40", locked_o, 1);
        for (int p = 41; p <= 51; p++) begin
            @(ref_rise);
            ref_period = p;
        end
        @(ref_rise);
        @(ref_rise);
        wait_cyc(10);
        chk("R5 still locked at deviation 11", state_o, 2);
        ref_period = 52;
        @(ref_rise);
        @(ref_rise);
        wait_cyc(10);
        chk("R5 drift beyond bound unlocks", state_o, 3);
    endtask

    task automatic t_timeout_R6;
        ref_period = 40;
        wait_lock(3000);
        chk("R6 locked before gap", locked_o, 1);
        @(ref_rise);
        ref_run = 0;
        wait_cyc(60);
        chk("R6 still locked inside window", state_o, 2);
        wait_cyc(40);
        chk("R6 missing edge unlocks", state_o, 3);
        ref_run = 1;
    endtask

    task automatic t_coincide_R11;
        do_reset(1'b0);
        ref_period = 40;
        ref_run = 1;
        repeat (8) @(ref_rise);
        ref_period = 48;
        @(ref_rise);
        wait_cyc(10);
        chk("R11 not locked one period early", locked_o, 0);
        @(ref_rise);
        wait_cyc(10);
        chk("R11 step wins over lock", state_o, 3);
        chk("R11 locked never set", locked_o, 0);
    endtask

    task automatic t_slow_R3;
        do_reset(1'b0);
        chk("R2 no hold leaves idle", state_o, 1);
        ref_period = 40;
        ref_run = 1;
        wait_cyc(330);
        chk("R3 period count not yet met", locked_o, 0);
        wait_cyc(90);
        chk("R3 locked by period count", locked_o, 1);
    endtask

    task automatic t_fast_R3;
        do_reset(1'b0);
        ref_period = 10;
        ref_run = 1;
        wait_cyc(150);
        chk("R3 fast ref waits for time", locked_o, 0);
        wait_cyc(150);
        chk("R3 fast ref locked by time", locked_o, 1);
    endtask

    initial begin
        t_reset_R1();
        t_startup_R2();
        t_bw_R10();
        t_relock_R7();
        t_step_R4();
        t_drift_R5();
        t_timeout_R6();
        t_coincide_R11();
        t_slow_R3();
        t_fast_R3();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule